// File: doc/BRIEF.md
# Parallel ATA Host Register Cycle Engine

This block lets a processor perform single register accesses on up to four parallel ATA buses without bit-banging the bus pins. Software first programs a configuration word holding an enable bit, a drive-reset bit and three cycle counts (address setup, strobe width, hold). It then writes one command word naming the target bus, the 3-bit drive register address, which of the two chip selects to assert, the direction and, for a write, the 16-bit value. The engine then runs the setup, strobe and hold phases on its own, each timed in clock cycles.

While a cycle runs, a busy flag is set and the transmitter-ready flag is clear. When a read finishes, the word sampled from the drive appears in the low half of the status word and a data-available flag is raised. Software polls these flags and does not issue a second command until busy has dropped. A second command written too early is ignored. One interrupt request line per bus is synchronised, latched and held until software acknowledges it with a one in the matching bit.

All bus-side outputs come straight from flops, so chip selects, strobes and the data-enable never glitch. Chip selects and strobes are active low and idle high.

Top module: `ata_pio_engine`

## Requirements
- R1: After reset: busy (status bit 17) and data-available (bit 16) are 0, transmitter ready (bit 18) is 1, every chip select and strobe is high, the data-enable is low, the drive reset line is high and no interrupt is pending.
- R2: An accepted command runs three phases. The setup phase has address and chip selects asserted with the strobe high. The strobe phase has the strobe low. The hold phase has the strobe high with chip selects still asserted. The phases last setupCnt (config bits 7:2), strobeCnt (bits 13:8) and holdCnt (bits 19:14) cycles, and a count of zero lasts one cycle.
- R3: Busy rises on the clock edge that accepts the command and stays high for exactly setup+strobe+hold cycles. Transmitter ready is its inverse.
- R4: Only the bus chosen by command bits 23:22 moves its strobe and chip-select lines. A read (command bit 21 = 1) pulses that bus's read strobe and a write pulses its write strobe. At most one strobe in the whole block is low at any time.
- R5: During a cycle the address output equals command bits 18:16. The selected bus drives its chip select 0 low when command bit 19 is 1 and its chip select 1 low when command bit 20 is 1.
- R6: For a write, the data-enable is high and the data output equals command bits 15:0 from the start of setup to the end of hold. For a read, the data-enable stays low.
- R7: A read captures the bus data on the edge that ends the strobe. When busy falls, status bits 15:0 hold that word and data-available is set. A write leaves data-available clear.
- R8: Data-available clears after a status read strobe and after an accepted command.
- R9: A command is ignored when the enable bit (config bit 0) is 0 or while busy is set. An ignored command starts no cycle and does not disturb a running one.
- R10: The drive reset line is low exactly while config bit 1 is set.
- R11: A high level on a bus's interrupt input sets that bus's pending bit after a two-flop synchroniser. The bit stays set until an acknowledge write carries a one in its position; acknowledging other bits leaves it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWr | input | 1 | Configuration write strobe |
| cfgWdata | input | 20 | Configuration word |
| cmdWr | input | 1 | Command write strobe |
| cmdWdata | input | 24 | Command word |
| statRd | input | 1 | Status read strobe (clears data-available) |
| statusOut | output | 19 | Status: read data, data-available, busy, transmitter ready |
| ackWr | input | 1 | Interrupt acknowledge strobe |
| ackMask | input | 4 | Bits of pending interrupts to clear |
| intrOut | output | 4 | Latched interrupt per bus |
| ataAddr | output | 3 | Drive register address |
| ataCs0N | output | 4 | Chip select 0 per bus, active low |
| ataCs1N | output | 4 | Chip select 1 per bus, active low |
| ataDiorN | output | 4 | Read strobe per bus, active low |
| ataDiowN | output | 4 | Write strobe per bus, active low |
| ataDataOut | output | 16 | Data driven to the bus |
| ataDataOe | output | 1 | Data output enable |
| ataDataIn | input | 16 | Data from the bus |
| ataIrq | input | 4 | Interrupt request per bus |
| ataResetN | output | 1 | Drive reset, active low |

## Verification
A phase counter that slips shows up at once as a setup, strobe or hold window on the bus pins that is one cycle too short or too long. The same slip also moves the cycle in which busy drops. If the captured command register is wrong, the wrong bus strobes or a stale address or data value appears within the first cycle after acceptance. A stuck data-available or pending-interrupt bit is visible in the status or interrupt outputs on the cycle after the clearing strobe.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam int NUM_BUS = 4;
  localparam int BUS_W   = $clog2(NUM_BUS);
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 3;
  localparam int CNT_W   = 6;
  localparam int CMD_W   = DATA_W + ADDR_W + 3 + BUS_W;
  localparam int CFG_W   = 2 + 3 * CNT_W;
  localparam int STAT_W  = DATA_W + 3;

  typedef struct packed {
    logic [BUS_W-1:0]  busSel;
    logic              isRead;
    logic              cs1;
    logic              cs0;
    logic [ADDR_W-1:0] regAddr;
    logic [DATA_W-1:0] wdata;
  } cmd_t;

  typedef struct packed {
    logic [CNT_W-1:0] holdCnt;
    logic [CNT_W-1:0] strobeCnt;
    logic [CNT_W-1:0] setupCnt;
    logic             rstOn;
    logic             enable;
  } cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic strobeOn;
    logic strobeOff;
    logic finish;
  } ctl_t;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

  // last tick value of a phase; a zero length behaves as one cycle
  function automatic logic [CNT_W-1:0] lastTick(input logic [CNT_W-1:0] len);
    return (len == '0) ? '0 : len - CNT_W'(1);
  endfunction
endpackage

// File: rtl/ata_pio_ctrl.sv
module ata_pio_ctrl
  import ata_pio_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWr,
  input  logic             enable,
  input  logic [CNT_W-1:0] setupLen,
  input  logic [CNT_W-1:0] strobeLen,
  input  logic [CNT_W-1:0] holdLen,
  output ctl_t             ctl,
  output logic             busy
);
  phase_e           phase;
  logic [CNT_W-1:0] tick;
  logic [CNT_W-1:0] strobeQ;
  logic [CNT_W-1:0] holdQ;
  logic             tickDone;

  assign tickDone = (tick == '0);

  always_comb begin
    ctl.accept    = cmdWr && enable && (phase == PH_IDLE);
    ctl.strobeOn  = (phase == PH_SETUP)  && tickDone;
    ctl.strobeOff = (phase == PH_STROBE) && tickDone;
    ctl.finish    = (phase == PH_HOLD)   && tickDone;
    busy          = (phase != PH_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      tick    <= '0;
      strobeQ <= '0;
      holdQ   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (ctl.accept) begin
            phase   <= PH_SETUP;
            tick    <= lastTick(setupLen);
            strobeQ <= strobeLen;
            holdQ   <= holdLen;
          end
        end
        PH_SETUP: begin
          if (tickDone) begin
            phase <= PH_STROBE;
            tick  <= lastTick(strobeQ);
          end else begin
            tick <= tick - CNT_W'(1);
          end
        end
        PH_STROBE: begin
          if (tickDone) begin
            phase <= PH_HOLD;
            tick  <= lastTick(holdQ);
          end else begin
            tick <= tick - CNT_W'(1);
          end
        end
        PH_HOLD: begin
          if (tickDone) phase <= PH_IDLE;
          else          tick  <= tick - CNT_W'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.accept |=> busy);

  // R9
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctl.accept);

  // R2
  ctl_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl));

  // R3
  finish_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finish |=> !busy);
endmodule

// File: rtl/ata_pio_dp.sv
module ata_pio_dp
  import ata_pio_pkg::*;
#(
  parameter int DEF_SETUP  = 9,
  parameter int DEF_STROBE = 39,
  parameter int DEF_HOLD   = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWr,
  input  logic [CFG_W-1:0]   cfgWdata,
  input  logic [CMD_W-1:0]   cmdWdata,
  input  logic               statRd,
  input  logic               ackWr,
  input  logic [NUM_BUS-1:0] ackMask,
  input  ctl_t               ctl,
  input  logic               busy,
  input  logic [DATA_W-1:0]  ataDataIn,
  input  logic [NUM_BUS-1:0] ataIrq,
  output cfg_t               cfgQ,
  output logic [STAT_W-1:0]  statusOut,
  output logic [NUM_BUS-1:0] intrOut,
  output logic [ADDR_W-1:0]  ataAddr,
  output logic [NUM_BUS-1:0] ataCs0N,
  output logic [NUM_BUS-1:0] ataCs1N,
  output logic [NUM_BUS-1:0] ataDiorN,
  output logic [NUM_BUS-1:0] ataDiowN,
  output logic [DATA_W-1:0]  ataDataOut,
  output logic               ataDataOe,
  output logic               ataResetN
);
  cmd_t               cmdIn;
  cmd_t               cmdQ;
  logic [DATA_W-1:0]  rdDataQ;
  logic               davQ;
  logic [NUM_BUS-1:0] irqMeta;
  logic [NUM_BUS-1:0] irqSync;
  logic [NUM_BUS-1:0] pendQ;
  logic               resetNQ;

  assign cmdIn = cmd_t'(cmdWdata);

  // configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ.enable    <= 1'b0;
      cfgQ.rstOn     <= 1'b0;
      cfgQ.setupCnt  <= CNT_W'(DEF_SETUP);
      cfgQ.strobeCnt <= CNT_W'(DEF_STROBE);
      cfgQ.holdCnt   <= CNT_W'(DEF_HOLD);
      resetNQ        <= 1'b1;
    end else begin
      if (cfgWr) begin
        cfgQ    <= cfg_t'(cfgWdata);
        resetNQ <= !cfgWdata[1];
      end
    end
  end
  assign ataResetN = resetNQ;

  // command capture, shared address and data outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ       <= '0;
      ataAddr    <= '0;
      ataDataOut <= '0;
      ataDataOe  <= 1'b0;
    end else if (ctl.accept) begin
      cmdQ       <= cmdIn;
      ataAddr    <= cmdIn.regAddr;
      ataDataOut <= cmdIn.wdata;
      ataDataOe  <= !cmdIn.isRead;
    end else if (ctl.finish) begin
      ataDataOe  <= 1'b0;
    end
  end

  // per-bus chip selects and strobes
  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    logic c0N, c1N, rdN, wrN;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        c0N <= 1'b1;
        c1N <= 1'b1;
        rdN <= 1'b1;
        wrN <= 1'b1;
      end else begin
        if (ctl.accept) begin
          c0N <= !(cmdIn.cs0 && (cmdIn.busSel == BUS_W'(b)));
          c1N <= !(cmdIn.cs1 && (cmdIn.busSel == BUS_W'(b)));
        end else if (ctl.finish) begin
          c0N <= 1'b1;
          c1N <= 1'b1;
        end
        if (ctl.strobeOn && (cmdQ.busSel == BUS_W'(b))) begin
          rdN <= !cmdQ.isRead;
          wrN <= cmdQ.isRead;
        end else if (ctl.strobeOff) begin
          rdN <= 1'b1;
          wrN <= 1'b1;
        end
      end
    end
    assign ataCs0N[b]  = c0N;
    assign ataCs1N[b]  = c1N;
    assign ataDiorN[b] = rdN;
    assign ataDiowN[b] = wrN;
  end

  // read capture and data-available
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ <= '0;
      davQ    <= 1'b0;
    end else begin
      if (ctl.strobeOff && cmdQ.isRead) rdDataQ <= ataDataIn;
      if (ctl.finish)       davQ <= cmdQ.isRead;
      else if (ctl.accept)  davQ <= 1'b0;
      else if (statRd)      davQ <= 1'b0;
    end
  end

  assign statusOut = {!busy, busy, davQ, rdDataQ};

  // interrupt latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqMeta <= '0;
      irqSync <= '0;
      pendQ   <= '0;
    end else begin
      irqMeta <= ataIrq;
      irqSync <= irqMeta;
      pendQ   <= (pendQ & ~(ackWr ? ackMask : '0)) | irqSync;
    end
  end
  assign intrOut = pendQ;

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({~ataDiorN, ~ataDiowN}) <= 1);

  // R6
  oe_write_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    ataDataOe |-> (!cmdQ.isRead && busy));

  // R7
  dav_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    davQ |-> !busy);

  // R8
  dav_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && !ctl.finish) |=> !davQ);

  // R10
  reset_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> (ataResetN == !$past(cfgWdata[1])));
endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter int DEF_SETUP  = 9,
  parameter int DEF_STROBE = 39,
  parameter int DEF_HOLD   = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWr,
  input  logic [CFG_W-1:0]   cfgWdata,
  input  logic               cmdWr,
  input  logic [CMD_W-1:0]   cmdWdata,
  input  logic               statRd,
  output logic [STAT_W-1:0]  statusOut,
  input  logic               ackWr,
  input  logic [NUM_BUS-1:0] ackMask,
  output logic [NUM_BUS-1:0] intrOut,
  output logic [ADDR_W-1:0]  ataAddr,
  output logic [NUM_BUS-1:0] ataCs0N,
  output logic [NUM_BUS-1:0] ataCs1N,
  output logic [NUM_BUS-1:0] ataDiorN,
  output logic [NUM_BUS-1:0] ataDiowN,
  output logic [DATA_W-1:0]  ataDataOut,
  output logic               ataDataOe,
  input  logic [DATA_W-1:0]  ataDataIn,
  input  logic [NUM_BUS-1:0] ataIrq,
  output logic               ataResetN
);
  ctl_t ctl;
  cfg_t cfgQ;
  logic busy;

  ata_pio_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWr    (cmdWr),
    .enable   (cfgQ.enable),
    .setupLen (cfgQ.setupCnt),
    .strobeLen(cfgQ.strobeCnt),
    .holdLen  (cfgQ.holdCnt),
    .ctl      (ctl),
    .busy     (busy)
  );

  ata_pio_dp #(
    .DEF_SETUP (DEF_SETUP),
    .DEF_STROBE(DEF_STROBE),
    .DEF_HOLD  (DEF_HOLD)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWr     (cfgWr),
    .cfgWdata  (cfgWdata),
    .cmdWdata  (cmdWdata),
    .statRd    (statRd),
    .ackWr     (ackWr),
    .ackMask   (ackMask),
    .ctl       (ctl),
    .busy      (busy),
    .ataDataIn (ataDataIn),
    .ataIrq    (ataIrq),
    .cfgQ      (cfgQ),
    .statusOut (statusOut),
    .intrOut   (intrOut),
    .ataAddr   (ataAddr),
    .ataCs0N   (ataCs0N),
    .ataCs1N   (ataCs1N),
    .ataDiorN  (ataDiorN),
    .ataDiowN  (ataDiowN),
    .ataDataOut(ataDataOut),
    .ataDataOe (ataDataOe),
    .ataResetN (ataResetN)
  );
endmodule

// File: tb/tb_ata_pio_engine.sv
module tb_ata_pio_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {isRead, bus[1:0], addr[2:0], cs0, cs1, setup[5:0], strobe[5:0], hold[5:0], data[15:0]}
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 2'd0, 3'd7, 1'b1, 1'b0, 6'd9, 6'd39, 6'd9, 16'h00EC},
    {1'b1, 2'd1, 3'd7, 1'b1, 1'b0, 6'd3, 6'd7,  6'd1, 16'h0050},
    {1'b0, 2'd2, 3'd6, 1'b0, 1'b1, 6'd3, 6'd9,  6'd3, 16'h0004},
    {1'b1, 2'd3, 3'd0, 1'b1, 1'b0, 6'd5, 6'd23, 6'd9, 16'hBEEF},
    {1'b0, 2'd1, 3'd0, 1'b1, 1'b0, 6'd0, 6'd0,  6'd0, 16'h1234},
    {1'b1, 2'd0, 3'd2, 1'b1, 1'b1, 6'd1, 6'd2,  6'd0, 16'h8001}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWr = 1'b0;
  logic [19:0] cfgWdata = '0;
  logic        cmdWr = 1'b0;
  logic [23:0] cmdWdata = '0;
  logic        statRd = 1'b0;
  logic [18:0] statusOut;
  logic        ackWr = 1'b0;
  logic [3:0]  ackMask = '0;
  logic [3:0]  intrOut;
  logic [2:0]  ataAddr;
  logic [3:0]  ataCs0N, ataCs1N, ataDiorN, ataDiowN;
  logic [15:0] ataDataOut;
  logic        ataDataOe;
  logic [15:0] ataDataIn;
  logic [3:0]  ataIrq = '0;
  logic        ataResetN;
  logic [15:0] driveVal = '0;

  int checks = 0;
  int fails = 0;

  assign ataDataIn = (ataDiorN != 4'hF) ? driveVal : 16'h0BAD;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_pio_engine dut (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgWdata(cfgWdata),
    .cmdWr(cmdWr), .cmdWdata(cmdWdata), .statRd(statRd), .statusOut(statusOut),
    .ackWr(ackWr), .ackMask(ackMask), .intrOut(intrOut), .ataAddr(ataAddr),
    .ataCs0N(ataCs0N), .ataCs1N(ataCs1N), .ataDiorN(ataDiorN), .ataDiowN(ataDiowN),
    .ataDataOut(ataDataOut), .ataDataOe(ataDataOe), .ataDataIn(ataDataIn),
    .ataIrq(ataIrq), .ataResetN(ataResetN)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [19:0] w);
    @(negedge clk); cfgWr = 1'b1; cfgWdata = w;
    @(negedge clk); cfgWr = 1'b0;
  endtask

  task automatic writeCmd(input logic [23:0] w);
    @(negedge clk); cmdWr = 1'b1; cmdWdata = w;
    @(negedge clk); cmdWr = 1'b0;
  endtask

  task automatic pulseStat();
    @(negedge clk); statRd = 1'b1;
    @(negedge clk); statRd = 1'b0;
  endtask

  task automatic pulseAck(input logic [3:0] m);
    @(negedge clk); ackWr = 1'b1; ackMask = m;
    @(negedge clk); ackWr = 1'b0; ackMask = '0;
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 300 && statusOut[17]; k++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", 32'(statusOut[18:16]), 32'b100);
    chk("R1 strobes", {ataDiorN, ataDiowN, ataCs0N, ataCs1N}, 32'hFFFF);
    chk("R1 oe/reset/intr", {ataDataOe, ataResetN, intrOut}, {1'b0, 1'b1, 4'h0});

    // table-driven cycles: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      logic rd, c0, c1;
      logic [1:0] bus;
      logic [2:0] adr;
      logic [5:0] s, t, h;
      logic [15:0] d;
      int es, et, eh, nS, nT, nH, nBusy, bad;
      logic [3:0] sel;
      v = VEC[i];
      rd = v[41]; bus = v[40:39]; adr = v[38:36]; c0 = v[35]; c1 = v[34];
      s = v[33:28]; t = v[27:22]; h = v[21:16]; d = v[15:0];
      es = (s == 0) ? 1 : int'(s);
      et = (t == 0) ? 1 : int'(t);
      eh = (h == 0) ? 1 : int'(h);
      sel = 4'(1 << bus);
      driveVal = d;
      writeCfg({h, t, s, 1'b0, 1'b1});
      writeCmd({bus, rd, c1, c0, adr, d});
      nS = 0; nT = 0; nH = 0; nBusy = 0; bad = 0;
      for (int k = 0; k < 300 && statusOut[17]; k++) begin
        nBusy++;
        if ((ataDiorN != 4'hF) || (ataDiowN != 4'hF)) begin
          nT++;
          if (ataDiorN != (rd ? ~sel : 4'hF)) bad |= 1;
          if (ataDiowN != (rd ? 4'hF : ~sel)) bad |= 1;
        end else if (nT == 0) nS++;
        else nH++;
        if (ataCs0N != (c0 ? ~sel : 4'hF)) bad |= 2;
        if (ataCs1N != (c1 ? ~sel : 4'hF)) bad |= 2;
        if (ataAddr != adr) bad |= 2;
        if (ataDataOe != !rd) bad |= 4;
        if (!rd && ataDataOut != d) bad |= 4;
        if (statusOut[18]) bad |= 8;
        @(negedge clk);
      end
      chk("R2 setup len", nS, es);
      chk("R2 strobe len", nT, et);
      chk("R2 hold len", nH, eh);
      chk("R3 busy len", nBusy, es + et + eh);
      chk("R3 ready inverse", bad & 8, 0);
      chk("R4 strobe lines", bad & 1, 0);
      chk("R5 addr/cs", bad & 2, 0);
      chk("R6 write data", bad & 4, 0);
      chk("R6 idle oe", {ataDataOe, ataCs0N, ataCs1N}, {1'b0, 8'hFF});
      if (rd) begin
        chk("R7 read word", {statusOut[16], statusOut[15:0]}, {1'b1, d});
        pulseStat();
        chk("R8 clear on status read", statusOut[16], 1'b0);
      end else begin
        chk("R7 no dav on write", statusOut[16], 1'b0);
      end
    end

    // R8 clear on accepted command
    driveVal = 16'h5A5A;
    writeCfg({6'd1, 6'd1, 6'd1, 1'b0, 1'b1});
    writeCmd({2'd0, 1'b1, 1'b0, 1'b1, 3'd1, 16'h0});
    waitIdle();
    chk("R8 dav set before", statusOut[16], 1'b1);
    writeCmd({2'd0, 1'b0, 1'b0, 1'b1, 3'd1, 16'h0});
    chk("R8 clear on command", statusOut[16], 1'b0);
    waitIdle();

    // R9 disabled engine ignores commands
    writeCfg({6'd2, 6'd2, 6'd2, 1'b0, 1'b0});
    writeCmd({2'd2, 1'b0, 1'b0, 1'b1, 3'd3, 16'hFFFF});
    chk("R9 disabled busy", statusOut[17], 1'b0);
    repeat (3) @(negedge clk);
    chk("R9 disabled pins", {ataCs0N, ataDiowN, ataDataOe}, {8'hFF, 1'b0});

    // R9 command while busy ignored
    writeCfg({6'd4, 6'd4, 6'd4, 1'b0, 1'b1});
    writeCmd({2'd0, 1'b0, 1'b0, 1'b1, 3'd1, 16'h1111});
    @(negedge clk); cmdWr = 1'b1; cmdWdata = {2'd3, 1'b0, 1'b0, 1'b1, 3'd5, 16'h2222};
    @(negedge clk); cmdWr = 1'b0;
    chk("R9 busy keeps cycle", {ataAddr, ataCs0N, ataDataOut}, {3'd1, 4'hE, 16'h1111});
    waitIdle();
    repeat (3) @(negedge clk);
    chk("R9 no late cycle", {statusOut[17], ataCs0N}, {1'b0, 4'hF});

    // R10 drive reset line
    writeCfg({6'd4, 6'd4, 6'd4, 1'b1, 1'b1});
    chk("R10 reset low", ataResetN, 1'b0);
    writeCfg({6'd4, 6'd4, 6'd4, 1'b0, 1'b1});
    chk("R10 reset high", ataResetN, 1'b1);

    // R11 interrupt latch and acknowledge
    @(negedge clk); ataIrq = 4'b0100;
    repeat (3) @(negedge clk);
    chk("R11 latched", intrOut, 4'b0100);
    ataIrq = 4'b0000;
    repeat (3) @(negedge clk);
    pulseAck(4'b0001);
    chk("R11 other ack keeps", intrOut, 4'b0100);
    pulseAck(4'b0100);
    chk("R11 ack clears", intrOut, 4'b0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule